// File: doc/BRIEF.md
# Line Hold Register with Alternating Column Polarity

This block sits between the serial data register of a column driver and its per-column output stage. When a horizontal line of gray codes has been collected, a pulse on the line strobe copies the whole line into a holding register. The same edge captures the polarity input. The held line is then presented to the output stage for the rest of the line period, while the data register fills with the next line.

For every column the block presents four things: the held code, a select that picks the upper or the lower half of the reference ladder, and the code split into a segment number and an offset within that segment. It also flags the single code that lands exactly on the last tap. Neighbouring columns always take opposite halves of the ladder, and the polarity input swaps the two halves. The drive enable is removed while the strobe is high, so every column floats. It returns on the first clock after the strobe falls, and the columns are then driven with the newly held levels.

The strobe is sampled on the block clock and must stay high for at least one clock edge. One strobe pulse is expected per line.

Top module: `line_hold_polar`

## Requirements
- R1: On a clock edge that samples `line_strobe` high after it was low at the previous edge, `col_code` takes the value of `row_data` at that edge. Column j occupies bits [j*CW +: CW].
- R2: From the edge that samples `line_strobe` high, every bit of `col_drive` is 0 (high impedance). It stays 0 while the strobe stays high.
- R3: On the first edge that samples `line_strobe` low after it was high, every bit of `col_drive` becomes 1. It stays 1 until the next rising strobe.
- R4: Between two rising strobes, `col_code` keeps its value, whatever `row_data` does.
- R5: `pol_swap` is sampled only at the rising strobe. With a sampled value of 0, column j (counted from 0) has `col_upper` = 1 for even j and 0 for odd j. A sampled value of 1 inverts every bit. A change of `pol_swap` at any other time has no effect.
- R6: `col_seg` for column j is the top two bits of its code, at bits [2j +: 2]. `col_ofs` for column j is the low CW-2 bits of its code, at bits [j*(CW-2) +: CW-2]. Segment 0 starts at code 00h, segment 1 at 10h, segment 2 at 20h and segment 3 at 30h.
- R7: `col_end[j]` is 1 exactly when the code of column j has all ones (3Fh for CW = 6).
- R8: After reset, `col_drive` is all 0, `col_code` is all 0 and the held polarity is 0. These values last until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_strobe | input | 1 | Line transfer strobe; high forces the columns to float |
| pol_swap | input | 1 | Swaps which ladder half odd and even columns use |
| row_data | input | NCOL*CW | Completed line from the data register, column 0 in the low bits |
| col_code | output | NCOL*CW | Held code for each column |
| col_upper | output | NCOL | 1 selects the upper ladder half for that column |
| col_seg | output | NCOL*2 | Segment number for each column |
| col_ofs | output | NCOL*(CW-2) | Offset within the segment for each column |
| col_end | output | NCOL | Code selects the final tap directly |
| col_drive | output | NCOL | Column driven (1) or high impedance (0) |

## Verification
The bench changes `row_data` and `pol_swap` while the strobe is still high and again after it falls. A design that latched on the level of the strobe, or that resampled the polarity, would show the changed values and fail the R4 and R5 checks. The enable is checked one edge after the strobe rises and again one edge after it falls. An enable that used the wrong edge or lagged a cycle would float the columns during the line, or drive them during the transfer. The code patterns sit on every segment start (00h, 10h, 20h, 30h) and on the 0Fh, 1Fh and 2Fh boundaries and 3Fh. This catches a split taken from the wrong bits and an end-tap flag that also fires on 30h or 0Fh.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
   // width of the segment number carved from the top of each code
   localparam int SEG_W = 2;

   typedef enum logic {
      DRV_FLOAT = 1'b0,
      DRV_ON    = 1'b1
   } drv_state_e;
endpackage

// File: rtl/lhp_strobe_ctl.sv
module lhp_strobe_ctl
   import lhp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic capture,
   output logic drive_on
);
   logic       strobe_d;
   drv_state_e state_q;

   // one-cycle pulse on the edge that first sees the strobe high
   assign capture  = strobe & ~strobe_d;
   assign drive_on = (state_q == DRV_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
         state_q  <= DRV_FLOAT;
      end else begin
         strobe_d <= strobe;
         if (strobe)
            state_q <= DRV_FLOAT;
         else if (strobe_d)
            state_q <= DRV_ON;
      end
   end
endmodule

// File: rtl/lhp_line_store.sv
module lhp_line_store #(
   parameter int NCOL = 300,
   parameter int CW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [NCOL*CW-1:0] row_in,
   input  logic              pol_in,
   output logic [NCOL*CW-1:0] row_q,
   output logic              pol_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         pol_q <= 1'b0;
      end else if (capture) begin
         row_q <= row_in;
         pol_q <= pol_in;
      end
   end
endmodule

// File: rtl/lhp_col_decode.sv
module lhp_col_decode
   import lhp_pkg::*;
#(
   parameter int CW     = 6,
   parameter bit ODD_IX = 1'b0,
   localparam int OFS_W = CW - SEG_W
) (
   input  logic [CW-1:0]    code,
   input  logic             pol,
   output logic             upper,
   output logic [SEG_W-1:0] seg,
   output logic [OFS_W-1:0] ofs,
   output logic             end_tap
);
   // column parity picks the default half; the polarity flips it
   generate
      if (ODD_IX) begin : g_second
         assign upper = pol;
      end else begin : g_first
         assign upper = ~pol;
      end
   endgenerate

   assign seg     = code[CW-1 -: SEG_W];
   assign ofs     = code[OFS_W-1:0];
   assign end_tap = &code;
endmodule

// File: rtl/line_hold_polar.sv
module line_hold_polar
   import lhp_pkg::*;
#(
   parameter int NCOL = 300,
   parameter int CW   = 6,
   localparam int OFS_W = CW - SEG_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  line_strobe,
   input  logic                  pol_swap,
   input  logic [NCOL*CW-1:0]    row_data,
   output logic [NCOL*CW-1:0]    col_code,
   output logic [NCOL-1:0]       col_upper,
   output logic [NCOL*SEG_W-1:0] col_seg,
   output logic [NCOL*OFS_W-1:0] col_ofs,
   output logic [NCOL-1:0]       col_end,
   output logic [NCOL-1:0]       col_drive
);
   generate
      if (NCOL < 2 || (NCOL % 2) != 0) begin : g_bad_ncol
         $error("NCOL must be even and at least 2");
      end
      if (CW <= SEG_W) begin : g_bad_cw
         $error("CW must exceed the segment width");
      end
   endgenerate

   logic capture;
   logic drive_on;
   logic pol_q;

   lhp_strobe_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (line_strobe),
      .capture  (capture),
      .drive_on (drive_on)
   );

   lhp_line_store #(.NCOL(NCOL), .CW(CW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .row_in  (row_data),
      .pol_in  (pol_swap),
      .row_q   (col_code),
      .pol_q   (pol_q)
   );

   assign col_drive = {NCOL{drive_on}};

   generate
      for (genvar j = 0; j < NCOL; j++) begin : g_col
         lhp_col_decode #(.CW(CW), .ODD_IX(j % 2 == 1)) u_dec (
            .code    (col_code[j*CW +: CW]),
            .pol     (pol_q),
            .upper   (col_upper[j]),
            .seg     (col_seg[j*SEG_W +: SEG_W]),
            .ofs     (col_ofs[j*OFS_W +: OFS_W]),
            .end_tap (col_end[j])
         );
      end
   endgenerate
endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
   parameter int NCOL = 300,
   parameter int CW   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               line_strobe,
   input logic               pol_swap,
   input logic [NCOL*CW-1:0] row_data,
   input logic [NCOL*CW-1:0] col_code,
   input logic [NCOL-1:0]    col_upper,
   input logic [NCOL-1:0]    col_drive
);
   logic stb_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_seen <= 1'b0;
      else        stb_seen <= line_strobe;
   end

   AST_LATCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && !stb_seen) |=> (col_code == $past(row_data))); // R1

   AST_FLOAT_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      line_strobe |=> (col_drive == '0)); // R2

   AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_strobe && stb_seen) |=> (col_drive == '1)); // R3

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_strobe && !stb_seen) |=> $stable(col_code)); // R4

   AST_POL_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (line_strobe && !stb_seen) |=> (col_upper[0] == !$past(pol_swap))); // R5

   AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_strobe && !stb_seen) |=> $stable(col_upper)); // R5
endmodule

bind line_hold_polar lhp_checker #(.NCOL(NCOL), .CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_strobe (line_strobe),
   .pol_swap    (pol_swap),
   .row_data    (row_data),
   .col_code    (col_code),
   .col_upper   (col_upper),
   .col_drive   (col_drive)
);

// File: tb/sim_line_hold_polar.sv
module sim_line_hold_polar;
   localparam int NCOL = 8;
   localparam int CW   = 6;
   localparam int DW   = NCOL * CW;
   localparam int NV   = 5;

   // {pol, codes column 7 .. column 0}
   localparam logic [DW:0] VEC [NV] = '{
      {1'b0, 6'h2F, 6'h1F, 6'h0F, 6'h3F, 6'h30, 6'h20, 6'h10, 6'h00},
      {1'b1, 6'h3F, 6'h3F, 6'h00, 6'h00, 6'h3E, 6'h01, 6'h31, 6'h2A},
      {1'b0, 6'h15, 6'h2A, 6'h15, 6'h2A, 6'h15, 6'h2A, 6'h15, 6'h2A},
      {1'b1, 6'h00, 6'h01, 6'h02, 6'h04, 6'h08, 6'h10, 6'h20, 6'h3F},
      {1'b1, 6'h3F, 6'h3F, 6'h3F, 6'h3F, 6'h3F, 6'h3F, 6'h3F, 6'h3F}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 line_strobe = 1'b0;
   logic                 pol_swap = 1'b0;
   logic [DW-1:0]        row_data = '0;
   logic [DW-1:0]        col_code;
   logic [NCOL-1:0]      col_upper;
   logic [NCOL*2-1:0]    col_seg;
   logic [NCOL*4-1:0]    col_ofs;
   logic [NCOL-1:0]      col_end;
   logic [NCOL-1:0]      col_drive;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   line_hold_polar #(.NCOL(NCOL), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .pol_swap(pol_swap),
      .row_data(row_data), .col_code(col_code), .col_upper(col_upper),
      .col_seg(col_seg), .col_ofs(col_ofs), .col_end(col_end), .col_drive(col_drive)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [NCOL-1:0] exp_upper(input logic p);
      logic [NCOL-1:0] r;
      for (int j = 0; j < NCOL; j++) r[j] = ((j % 2) == 0) ^ p;
      return r;
   endfunction

   function automatic logic [NCOL*2-1:0] exp_seg(input logic [DW-1:0] d);
      logic [NCOL*2-1:0] r;
      for (int j = 0; j < NCOL; j++) r[2*j +: 2] = d[j*CW + 4 +: 2];
      return r;
   endfunction

   function automatic logic [NCOL*4-1:0] exp_ofs(input logic [DW-1:0] d);
      logic [NCOL*4-1:0] r;
      for (int j = 0; j < NCOL; j++) r[4*j +: 4] = d[j*CW +: 4];
      return r;
   endfunction

   function automatic logic [NCOL-1:0] exp_end(input logic [DW-1:0] d);
      logic [NCOL-1:0] r;
      for (int j = 0; j < NCOL; j++) r[j] = (d[j*CW +: CW] == 6'h3F);
      return r;
   endfunction

   // one full line: rise, stir inputs while high, fall, stir again
   task automatic run_line(input logic [DW-1:0] d, input logic p, input int hi_cycles);
      @(negedge clk);
      row_data    = d;
      pol_swap    = p;
      line_strobe = 1'b1;
      @(negedge clk);
      check("R2 drive off after rise", 64'(col_drive), 64'(0));
      check("R1 code latched", 64'(col_code), 64'(d));
      row_data = ~d;
      pol_swap = ~p;
      for (int k = 1; k < hi_cycles; k++) @(negedge clk);
      check("R2 drive off while high", 64'(col_drive), 64'(0));
      line_strobe = 1'b0;
      @(negedge clk);
      check("R3 drive on after fall", 64'(col_drive), {56'(0), {NCOL{1'b1}}});
      check("R4 code held", 64'(col_code), 64'(d));
      check("R5 upper select", 64'(col_upper), 64'(exp_upper(p)));
      check("R6 segment", 64'(col_seg), 64'(exp_seg(d)));
      check("R6 offset", 64'(col_ofs), 64'(exp_ofs(d)));
      check("R7 end tap", 64'(col_end), 64'(exp_end(d)));
      row_data = d ^ 48'h5A5_A5A_5A5_A5A;
      @(negedge clk);
      @(negedge clk);
      check("R4 code ignores row_data", 64'(col_code), 64'(d));
      check("R5 pol ignored after rise", 64'(col_upper), 64'(exp_upper(p)));
      check("R3 drive stays on", 64'(col_drive), {56'(0), {NCOL{1'b1}}});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check("R8 drive after reset", 64'(col_drive), 64'(0));
      check("R8 code after reset", 64'(col_code), 64'(0));
      check("R8 polarity after reset", 64'(col_upper), 64'(exp_upper(1'b0)));
      pol_swap = 1'b1;
      row_data = '1;
      @(negedge clk);
      check("R8 held before first strobe", 64'(col_drive), 64'(0));
      check("R5 pol ignored without strobe", 64'(col_upper), 64'(exp_upper(1'b0)));

      for (int v = 0; v < NV; v++)
         run_line(VEC[v][DW-1:0], VEC[v][DW], 1 + (v % 3));

      // directed: long strobe keeps columns floating, then same line again
      run_line(VEC[0][DW-1:0], 1'b1, 6);
      // directed: back-to-back polarity flips
      run_line(VEC[2][DW-1:0], 1'b0, 1);
      run_line(VEC[2][DW-1:0], 1'b1, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule